// File: doc/BRIEF.md
# Register Window Address Mapper

This block places a processor's sixteen word-wide general-purpose registers inside a shared on-chip word RAM instead of a bank of flops. A base-pointer register holds the byte address where the active register window starts. Each register access turns a 4-bit register number into a RAM word address by adding it to that base. There are two read ports and one write port. The RAM sits outside the block, and the block drives its address, write-enable and write-data lines.

Loading a new base pointer switches to another register bank. Because any word-aligned base is legal, a new window can overlap the old one. The registers that the two windows share then hand values from one context to the next without any copying. The number of windows is bounded only by the RAM size.

A window that runs past the last RAM word wraps back to the bottom of the RAM and raises an error flag on the port concerned. When a write and a read target the same RAM word in the same cycle, the read returns the data being written.

Top module: `cpmap_top`

## Requirements
- R1: After reset the base pointer holds byte address CP_RESET (default 0), so register n maps to RAM word n.
- R2: Register n maps to RAM word address (base byte address / 2) + n. A register numbered one higher maps to the next word.
- R3: Bit 0 of a loaded base value is ignored. A loaded value v acts as v with bit 0 cleared.
- R4: When `cp_load` is high at a rising clock edge, `cp_value` is captured. All three ports use the new base from the following cycle onward. In the loading cycle itself they still use the old base.
- R5: If base byte address + 2n is at least RAM_BYTES, the word address wraps modulo RAM_BYTES/2 and the port's error flag (`rd_err_a`, `rd_err_b` or `wr_err`) is 1. Otherwise the flag is 0. Register 0 never sets the flag.
- R6: If `wr_en` is 1 and a read port's word address equals the write word address in the same cycle, that port's read data equals `wr_data`.
- R7: Otherwise, each read port's data equals the RAM data returned for that port's address.
- R8: The write port drives `ram_wr_en` = `wr_en`, forwards `wr_data`, and maps `wr_reg` the same way as a read port. With `wr_en` at 0 the RAM is left unchanged and `wr_err` is 0.
- R9: Windows may overlap. A register written through one base can be read through another base that reaches the same RAM word under a different register number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cp_load | input | 1 | Load a new base pointer at this edge |
| cp_value | input | 10 | New base byte address (bit 0 ignored) |
| rd_reg_a | input | 4 | Register number, read port A |
| rd_reg_b | input | 4 | Register number, read port B |
| wr_en | input | 1 | Write request |
| wr_reg | input | 4 | Register number, write port |
| wr_data | input | 16 | Write data |
| ram_rd_addr_a | output | 9 | RAM word address, read port A |
| ram_rd_addr_b | output | 9 | RAM word address, read port B |
| ram_rd_data_a | input | 16 | RAM data for read port A |
| ram_rd_data_b | input | 16 | RAM data for read port B |
| ram_wr_en | output | 1 | RAM write strobe |
| ram_wr_addr | output | 9 | RAM word address, write port |
| ram_wr_data | output | 16 | RAM write data |
| rd_data_a | output | 16 | Register data, read port A |
| rd_data_b | output | 16 | Register data, read port B |
| rd_err_a | output | 1 | Window overrun on read port A |
| rd_err_b | output | 1 | Window overrun on read port B |
| wr_err | output | 1 | Window overrun on the write port |

## Verification
The bench builds the block with its default parameters: 16-bit words, 16 registers, a 1 KB RAM and a reset base of zero. With these values a 10-bit base pointer can put the window on the RAM's last few words. That makes the wrap boundary, the ignored low bit and the register-0 no-overflow case all reachable with a handful of loads. The RAM model in the bench is preloaded with an address-derived pattern. This lets read data, forwarding and window overlap be checked against known words.

// File: rtl/cpmap_pkg.sv
`timescale 1ns/1ps
package cpmap_pkg;

    // Result of mapping a register number through the current window.
    typedef enum logic [0:0] {
        MAP_OK      = 1'b0,
        MAP_WRAPPED = 1'b1
    } map_status_e;

    localparam int NUM_RD_PORTS = 2;

endpackage

// File: rtl/cpmap_cp_reg.sv
`timescale 1ns/1ps
module cpmap_cp_reg #(
    parameter int BYTE_AW  = 10,
    parameter int CP_RESET = 0,
    localparam int WORD_AW = BYTE_AW - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [BYTE_AW-1:0] value,
    output logic [WORD_AW-1:0] base_word
);

    localparam logic [BYTE_AW-1:0] RESET_BYTE = BYTE_AW'(CP_RESET);

    // The low byte-address bit is dropped: windows are always word aligned.
    logic unused_cp_lsb;
    assign unused_cp_lsb = value[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_word <= RESET_BYTE[BYTE_AW-1:1];
        end else if (load) begin
            base_word <= value[BYTE_AW-1:1];
        end
    end

endmodule

// File: rtl/cpmap_addr_gen.sv
`timescale 1ns/1ps
module cpmap_addr_gen
    import cpmap_pkg::*;
#(
    parameter int WORD_AW = 9,
    parameter int REG_W   = 4
) (
    input  logic [WORD_AW-1:0] base_word,
    input  logic [REG_W-1:0]   reg_num,
    output logic [WORD_AW-1:0] word_addr,
    output map_status_e        status
);

    // One carry bit beyond the RAM's word range detects a run past the end.
    logic [WORD_AW:0] sum;

    always_comb begin
        sum       = {1'b0, base_word} + {{(WORD_AW + 1 - REG_W){1'b0}}, reg_num};
        word_addr = sum[WORD_AW-1:0];
        status    = sum[WORD_AW] ? MAP_WRAPPED : MAP_OK;
    end

endmodule

// File: rtl/cpmap_fwd.sv
`timescale 1ns/1ps
module cpmap_fwd #(
    parameter int DATA_W  = 16,
    parameter int WORD_AW = 9
) (
    input  logic               wr_en,
    input  logic [WORD_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [WORD_AW-1:0] rd_addr,
    input  logic [DATA_W-1:0]  ram_data,
    output logic [DATA_W-1:0]  rd_data
);

    // Compare RAM word addresses, not register numbers, so that any aliasing
    // through the window is covered.
    always_comb begin
        if (wr_en && (wr_addr == rd_addr)) begin
            rd_data = wr_data;
        end else begin
            rd_data = ram_data;
        end
    end

endmodule

// File: rtl/cpmap_top.sv
`timescale 1ns/1ps
module cpmap_top
    import cpmap_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int NUM_REGS  = 16,
    parameter int RAM_BYTES = 1024,
    parameter int CP_RESET  = 0,
    localparam int BYTE_AW  = $clog2(RAM_BYTES),
    localparam int WORD_AW  = BYTE_AW - 1,
    localparam int REG_W    = $clog2(NUM_REGS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cp_load,
    input  logic [BYTE_AW-1:0] cp_value,
    input  logic [REG_W-1:0]   rd_reg_a,
    input  logic [REG_W-1:0]   rd_reg_b,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_reg,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [WORD_AW-1:0] ram_rd_addr_a,
    output logic [WORD_AW-1:0] ram_rd_addr_b,
    input  logic [DATA_W-1:0]  ram_rd_data_a,
    input  logic [DATA_W-1:0]  ram_rd_data_b,
    output logic               ram_wr_en,
    output logic [WORD_AW-1:0] ram_wr_addr,
    output logic [DATA_W-1:0]  ram_wr_data,
    output logic [DATA_W-1:0]  rd_data_a,
    output logic [DATA_W-1:0]  rd_data_b,
    output logic               rd_err_a,
    output logic               rd_err_b,
    output logic               wr_err
);

    logic [WORD_AW-1:0] base_word;

    logic [REG_W-1:0]   rd_reg   [NUM_RD_PORTS];
    logic [WORD_AW-1:0] rd_word  [NUM_RD_PORTS];
    map_status_e        rd_stat  [NUM_RD_PORTS];
    logic [DATA_W-1:0]  ram_data [NUM_RD_PORTS];
    logic [DATA_W-1:0]  rd_out   [NUM_RD_PORTS];

    logic [WORD_AW-1:0] wr_word;
    map_status_e        wr_stat;

    cpmap_cp_reg #(
        .BYTE_AW  (BYTE_AW),
        .CP_RESET (CP_RESET)
    ) cp_reg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cp_load),
        .value     (cp_value),
        .base_word (base_word)
    );

    assign rd_reg[0]   = rd_reg_a;
    assign rd_reg[1]   = rd_reg_b;
    assign ram_data[0] = ram_rd_data_a;
    assign ram_data[1] = ram_rd_data_b;

    for (genvar p = 0; p < NUM_RD_PORTS; p++) begin : g_rd_port
        cpmap_addr_gen #(
            .WORD_AW (WORD_AW),
            .REG_W   (REG_W)
        ) addr_i (
            .base_word (base_word),
            .reg_num   (rd_reg[p]),
            .word_addr (rd_word[p]),
            .status    (rd_stat[p])
        );

        cpmap_fwd #(
            .DATA_W  (DATA_W),
            .WORD_AW (WORD_AW)
        ) fwd_i (
            .wr_en    (wr_en),
            .wr_addr  (wr_word),
            .wr_data  (wr_data),
            .rd_addr  (rd_word[p]),
            .ram_data (ram_data[p]),
            .rd_data  (rd_out[p])
        );
    end

    cpmap_addr_gen #(
        .WORD_AW (WORD_AW),
        .REG_W   (REG_W)
    ) wr_addr_i (
        .base_word (base_word),
        .reg_num   (wr_reg),
        .word_addr (wr_word),
        .status    (wr_stat)
    );

    always_comb begin
        ram_rd_addr_a = rd_word[0];
        ram_rd_addr_b = rd_word[1];
        rd_data_a     = rd_out[0];
        rd_data_b     = rd_out[1];
        rd_err_a      = (rd_stat[0] == MAP_WRAPPED);
        rd_err_b      = (rd_stat[1] == MAP_WRAPPED);
        ram_wr_en     = wr_en;
        ram_wr_addr   = wr_word;
        ram_wr_data   = wr_data;
        wr_err        = wr_en && (wr_stat == MAP_WRAPPED);
    end

endmodule

// File: rtl/cpmap_top_chk.sv
`timescale 1ns/1ps
module cpmap_top_chk #(
    parameter int DATA_W  = 16,
    parameter int WORD_AW = 9,
    parameter int REG_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cp_load,
    input logic [REG_W-1:0]   rd_reg_a,
    input logic [REG_W-1:0]   rd_reg_b,
    input logic               wr_en,
    input logic [DATA_W-1:0]  wr_data,
    input logic [WORD_AW-1:0] ram_rd_addr_a,
    input logic [WORD_AW-1:0] ram_rd_addr_b,
    input logic [DATA_W-1:0]  ram_rd_data_a,
    input logic [WORD_AW-1:0] ram_wr_addr,
    input logic [DATA_W-1:0]  rd_data_a,
    input logic               rd_err_a,
    input logic               rd_err_b,
    input logic               wr_err
);

    // Without a load, the same register number keeps mapping to the same word.
    assert_cp_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cp_load |=> (rd_reg_a != $past(rd_reg_a)) || (ram_rd_addr_a == $past(ram_rd_addr_a)));

    assert_wr_forward_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (ram_wr_addr == ram_rd_addr_a)) |-> (rd_data_a == wr_data));

    assert_ram_path_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (ram_wr_addr == ram_rd_addr_a)) |-> (rd_data_a == ram_rd_data_a));

    assert_r0_no_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_reg_a == '0) |-> !rd_err_a);

    assert_adjacent_words_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_reg_b == rd_reg_a + 1'b1) && (rd_reg_a != '1) && !rd_err_b)
            |-> (ram_rd_addr_b == ram_rd_addr_a + 1'b1));

    assert_wr_err_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> !wr_err);

endmodule

bind cpmap_top cpmap_top_chk #(
    .DATA_W  (DATA_W),
    .WORD_AW (WORD_AW),
    .REG_W   (REG_W)
) chk_i (.*);

// File: tb/cpmap_top_tb_top.sv
`timescale 1ns/1ps
module cpmap_top_tb_top;

    localparam int DW = 16;
    localparam int WORDS = 512;
    localparam int NVEC = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cp_load = 1'b0;
    logic [9:0]  cp_value = '0;
    logic [3:0]  rd_reg_a = '0;
    logic [3:0]  rd_reg_b = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_reg = '0;
    logic [15:0] wr_data = '0;
    logic [8:0]  ram_rd_addr_a, ram_rd_addr_b, ram_wr_addr;
    logic [15:0] ram_rd_data_a, ram_rd_data_b, ram_wr_data;
    logic [15:0] rd_data_a, rd_data_b;
    logic        ram_wr_en, rd_err_a, rd_err_b, wr_err;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    // RAM model: asynchronous read, write at the rising edge, preloaded in reset.
    logic [DW-1:0] mem [WORDS];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= 16'hA000 + 16'(i);
        end else if (ram_wr_en) begin
            mem[ram_wr_addr] <= ram_wr_data;
        end
    end
    assign ram_rd_data_a = mem[ram_rd_addr_a];
    assign ram_rd_data_b = mem[ram_rd_addr_b];

    cpmap_top dut_i (
        .clk(clk), .rst_n(rst_n), .cp_load(cp_load), .cp_value(cp_value),
        .rd_reg_a(rd_reg_a), .rd_reg_b(rd_reg_b), .wr_en(wr_en), .wr_reg(wr_reg),
        .wr_data(wr_data), .ram_rd_addr_a(ram_rd_addr_a), .ram_rd_addr_b(ram_rd_addr_b),
        .ram_rd_data_a(ram_rd_data_a), .ram_rd_data_b(ram_rd_data_b),
        .ram_wr_en(ram_wr_en), .ram_wr_addr(ram_wr_addr), .ram_wr_data(ram_wr_data),
        .rd_data_a(rd_data_a), .rd_data_b(rd_data_b), .rd_err_a(rd_err_a),
        .rd_err_b(rd_err_b), .wr_err(wr_err)
    );

    // Vector: {cp_value[9:0], reg[3:0], expected word[8:0], expected error}
    localparam logic [23:0] VEC [NVEC] = '{
        {10'h000, 4'd0,  9'd0,   1'b0},
        {10'h000, 4'd15, 9'd15,  1'b0},
        {10'h021, 4'd3,  9'd19,  1'b0},  // R3: bit 0 ignored
        {10'h100, 4'd7,  9'd135, 1'b0},
        {10'h3E0, 4'd15, 9'd511, 1'b0},
        {10'h3E2, 4'd15, 9'd0,   1'b1},
        {10'h3FE, 4'd0,  9'd511, 1'b0},
        {10'h3FE, 4'd1,  9'd0,   1'b1},
        {10'h3FF, 4'd2,  9'd1,   1'b1}   // R3 and R5 together
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_cp(input logic [9:0] v);
        @(negedge clk);
        cp_load = 1'b1;
        cp_value = v;
        @(negedge clk);
        cp_load = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset base maps register n to word n
        @(negedge clk);
        rd_reg_a = 4'd5;
        rd_reg_b = 4'd15;
        #2;
        chk("R1 addr_a", 32'(ram_rd_addr_a), 32'd5);
        chk("R1 addr_b", 32'(ram_rd_addr_b), 32'd15);
        chk("R1 err", 32'({rd_err_a, rd_err_b}), 32'd0);

        // R2 R3 R5: table of bases and register numbers
        for (int k = 0; k < NVEC; k++) begin
            load_cp(VEC[k][23:14]);
            rd_reg_a = VEC[k][13:10];
            rd_reg_b = VEC[k][13:10];
            #2;
            chk("R2 R3 R5 table addr_a", 32'(ram_rd_addr_a), 32'(VEC[k][9:1]));
            chk("R2 R5 table addr_b", 32'(ram_rd_addr_b), 32'(VEC[k][9:1]));
            chk("R5 table err_a", 32'(rd_err_a), 32'(VEC[k][0]));
            chk("R5 table err_b", 32'(rd_err_b), 32'(VEC[k][0]));
        end

        // R4: old base in the loading cycle, new base after the edge
        load_cp(10'h000);
        cp_load = 1'b1;
        cp_value = 10'h040;
        rd_reg_a = 4'd1;
        #2;
        chk("R4 old base during load", 32'(ram_rd_addr_a), 32'd1);
        @(negedge clk);
        cp_load = 1'b0;
        #2;
        chk("R4 new base after load", 32'(ram_rd_addr_a), 32'd33);

        // R7: plain read from RAM (base word 32)
        rd_reg_a = 4'd2;
        rd_reg_b = 4'd3;
        #2;
        chk("R7 data_a", 32'(rd_data_a), 32'hA022);
        chk("R7 data_b", 32'(rd_data_b), 32'hA023);

        // R8: no write strobe leaves RAM untouched
        wr_en = 1'b0;
        wr_reg = 4'd3;
        wr_data = 16'h1234;
        #2;
        chk("R8 strobe low", 32'(ram_wr_en), 32'd0);
        chk("R8 wr_err low", 32'(wr_err), 32'd0);
        @(negedge clk);
        #2;
        chk("R8 ignored write", 32'(rd_data_b), 32'hA023);

        // R6: same-cycle write forwards; R7: other port reads RAM
        wr_en = 1'b1;
        wr_reg = 4'd4;
        wr_data = 16'h5A5A;
        rd_reg_a = 4'd4;
        rd_reg_b = 4'd5;
        #2;
        chk("R8 strobe high", 32'(ram_wr_en), 32'd1);
        chk("R8 write addr", 32'(ram_wr_addr), 32'd36);
        chk("R8 write data", 32'(ram_wr_data), 32'h5A5A);
        chk("R6 forward", 32'(rd_data_a), 32'h5A5A);
        chk("R7 neighbour", 32'(rd_data_b), 32'hA025);
        @(negedge clk);
        wr_en = 1'b0;
        #2;
        chk("R8 written value", 32'(rd_data_a), 32'h5A5A);

        // R5: write port overrun wraps to word 0 and flags
        load_cp(10'h3FE);
        wr_en = 1'b1;
        wr_reg = 4'd1;
        wr_data = 16'h1111;
        #2;
        chk("R5 wr_err", 32'(wr_err), 32'd1);
        chk("R5 wr wrap addr", 32'(ram_wr_addr), 32'd0);
        @(negedge clk);
        wr_en = 1'b0;

        // R9: overlapping windows share words
        load_cp(10'h000);
        rd_reg_a = 4'd0;
        #2;
        chk("R5 wrapped write landed", 32'(rd_data_a), 32'h1111);
        wr_en = 1'b1;
        wr_reg = 4'd8;
        wr_data = 16'hBEEF;
        @(negedge clk);
        wr_en = 1'b0;
        load_cp(10'h010);
        rd_reg_a = 4'd0;
        rd_reg_b = 4'd1;
        #2;
        chk("R9 overlap shared word", 32'(rd_data_a), 32'hBEEF);
        chk("R9 overlap next word", 32'(rd_data_b), 32'hA009);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule